// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block holds the three program-counter values of a pipeline front end with one architectural branch delay slot. These are the address of the instruction now retiring (`pc`), the address of the instruction after it (`npc`, the delay slot when `pc` holds a control transfer), and the address after that (`nnpc`). Each time an instruction retires, the block takes that instruction's decoded transfer class, its condition result, its immediate fields and an optional register operand. It resolves the new fetch addresses and shifts the triplet forward by one position. While no instruction retires, all three values stay unchanged.

Ordinary conditional branches always let the delay slot execute. The "likely" form of a branch annuls its delay slot when the branch is not taken, and flags this on `annul`. Direct jumps build their target inside the current 256 MiB region. Register jumps take an aligned register value and copy the low mode bit of `npc` into the target. Any control transfer with its link option set produces a return-address write, so that the register file can load the address that follows the delay slot. Condition evaluation, the register file and instruction fetch are outside this block.

Top module: `dsnpc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the triplet loads `pc`=RESET_VEC, `npc`=RESET_VEC+4 and `nnpc`=RESET_VEC+8.
- R2: When `retire` is low, `pc`, `npc` and `nnpc` keep their values, and `annul` and `link_we` are 0.
- R3: A retiring instruction with `xfer_class` 0, or with an unused code 5 to 7, moves the triplet forward: new `pc` = old `npc`, new `npc` = old `nnpc`, new `nnpc` = old `nnpc`+4.
- R4: `xfer_class` 1 (conditional branch) with `cond_true` high is taken. New `pc` = old `npc`, new `npc` = old `npc` + disp, and new `nnpc` = that target + 4. Here disp is `offset` shifted left by two and sign-extended from bit 17.
- R5: `xfer_class` 1 with the condition false moves the triplet forward as in R3, and `annul` stays 0.
- R6: `xfer_class` 2 (branch-likely) acts as R4 when taken. When it is not taken, `annul` is 1 in the retire cycle, and afterwards `pc` = old `nnpc`, `npc` = old `nnpc`+4 and `nnpc` = old `nnpc`+8. `annul` is 1 in no other case.
- R7: With `cond_forced` high, a branch of class 1 or 2 is taken whatever the value of `cond_true`.
- R8: `xfer_class` 3 (direct jump) sets new `npc` to {old `npc`[31:28], `jump_index`, 2'b00}, with new `pc` = old `npc`.
- R9: `xfer_class` 4 (register jump) sets new `npc` to `reg_value` with bits 1:0 cleared and bit 0 replaced by old `npc`[0].
- R10: `link_we` is 1 exactly in a retire cycle where `link_en` is high and `xfer_class` is 1 to 4, whether or not a branch is taken. `link_data` always equals the current `nnpc`.
- R11: An offset with bit 15 set gives a negative displacement. For example, `offset`=16'h8000 moves the target back by 0x20000 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | The instruction at `pc` retires this cycle |
| xfer_class | input | 3 | 0 none, 1 branch, 2 branch-likely, 3 direct jump, 4 register jump |
| link_en | input | 1 | The transfer writes a return address |
| cond_true | input | 1 | Branch condition result |
| cond_forced | input | 1 | Branch condition is hard-wired true |
| offset | input | 16 | Branch word offset |
| jump_index | input | 26 | Direct-jump word index |
| reg_value | input | 32 | Source register for register jumps |
| pc | output | 32 | Address of the retiring instruction |
| npc | output | 32 | Following address (delay slot) |
| nnpc | output | 32 | Address after the delay slot |
| link_we | output | 1 | Return-address write enable |
| link_data | output | 32 | Return address |
| annul | output | 1 | Delay slot skipped |

## Verification
The bench targets the cases where the delay slot is easy to get wrong. If a branch target were taken from `pc` instead of `npc`, every taken branch would land 4 bytes short. If a branch-likely that is not taken failed to annul, the delay-slot address would reappear in `pc`. The bench uses a backward offset with bit 15 set, which would turn into a large forward jump if the sign extension were lost. It checks that a link write appears for a not-taken linking branch and is absent for a plain instruction with the link flag set, and that its data is the pre-update `nnpc`. A second instance with an odd reset vector shows whether a register jump carries `npc`[0] into the target or drops it.

// File: rtl/dsnpc_pkg.sv
package dsnpc_pkg;

    localparam int PC_W   = 32;
    localparam int OFF_W  = 16;
    localparam int IDX_W  = 26;
    localparam int STEP   = 4;
    localparam int REGION_W = PC_W - IDX_W - 2;
    localparam int DISP_PAD = PC_W - OFF_W - 2;

    typedef enum logic [2:0] {
        XF_SEQ  = 3'd0,
        XF_BR   = 3'd1,
        XF_BRL  = 3'd2,
        XF_JDIR = 3'd3,
        XF_JREG = 3'd4
    } xfer_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] npc;
        logic [PC_W-1:0] nnpc;
    } pc_trip_t;

    typedef struct packed {
        xfer_e kind;
        logic  is_branch;
        logic  is_ctrl;
        logic  links;
    } dec_t;

    typedef struct packed {
        logic [PC_W-1:0] br;
        logic [PC_W-1:0] jdir;
        logic [PC_W-1:0] jreg;
    } tgt_t;

    function automatic logic [PC_W-1:0] br_disp(input logic [OFF_W-1:0] off);
        return {{DISP_PAD{off[OFF_W-1]}}, off, 2'b00};
    endfunction

    function automatic logic [PC_W-1:0] jdir_addr(input logic [PC_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        return {base[PC_W-1 -: REGION_W], idx, 2'b00};
    endfunction

    function automatic logic [PC_W-1:0] jreg_addr(input logic [PC_W-1:0] rv,
                                                  input logic [PC_W-1:0] base);
        return {rv[PC_W-1:2], 1'b0, base[0]};
    endfunction

endpackage

// File: rtl/dsnpc_decode.sv
module dsnpc_decode
    import dsnpc_pkg::*;
(
    input  logic [2:0] cls_raw,
    input  logic       link_en,
    output dec_t       dec
);
    always_comb begin
        dec.kind      = XF_SEQ;
        dec.is_branch = 1'b0;
        dec.is_ctrl   = 1'b0;
        case (cls_raw)
            3'd1: begin dec.kind = XF_BR;   dec.is_branch = 1'b1; dec.is_ctrl = 1'b1; end
            3'd2: begin dec.kind = XF_BRL;  dec.is_branch = 1'b1; dec.is_ctrl = 1'b1; end
            3'd3: begin dec.kind = XF_JDIR; dec.is_ctrl = 1'b1; end
            3'd4: begin dec.kind = XF_JREG; dec.is_ctrl = 1'b1; end
            default: dec.kind = XF_SEQ;
        endcase
        dec.links = dec.is_ctrl & link_en;
    end
endmodule

// File: rtl/dsnpc_target.sv
module dsnpc_target
    import dsnpc_pkg::*;
(
    input  logic [PC_W-1:0]  npc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IDX_W-1:0] jump_index,
    input  logic [PC_W-1:0]  reg_value,
    output tgt_t             tgt
);
    always_comb begin
        tgt.br   = npc + br_disp(offset);
        tgt.jdir = jdir_addr(npc, jump_index);
        tgt.jreg = jreg_addr(reg_value, npc);
    end
endmodule

// File: rtl/dsnpc_resolve.sv
module dsnpc_resolve
    import dsnpc_pkg::*;
(
    input  logic            retire,
    input  dec_t            dec,
    input  logic            cond_true,
    input  logic            cond_forced,
    input  pc_trip_t        cur,
    input  tgt_t            tgt,
    output logic [PC_W-1:0] exec_npc,
    output logic [PC_W-1:0] exec_nnpc,
    output logic            annul,
    output logic            link_we
);
    logic taken;

    always_comb begin
        taken     = cond_true | cond_forced;
        exec_npc  = cur.npc;
        exec_nnpc = cur.nnpc;
        annul     = 1'b0;
        case (dec.kind)
            XF_BR:   if (taken) exec_nnpc = tgt.br;
            XF_BRL: begin
                if (taken) begin
                    exec_nnpc = tgt.br;
                end else begin
                    exec_npc  = cur.nnpc;
                    exec_nnpc = cur.nnpc + PC_W'(STEP);
                    annul     = 1'b1;
                end
            end
            XF_JDIR: exec_nnpc = tgt.jdir;
            XF_JREG: exec_nnpc = tgt.jreg;
            default: ;
        endcase
        annul   = annul & retire;
        link_we = dec.links & retire;
    end
endmodule

// File: rtl/dsnpc_state.sv
module dsnpc_state
    import dsnpc_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0040_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            retire,
    input  logic [PC_W-1:0] exec_npc,
    input  logic [PC_W-1:0] exec_nnpc,
    output pc_trip_t        cur
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.pc   <= RESET_VEC;
            cur.npc  <= RESET_VEC + STEP_V;
            cur.nnpc <= RESET_VEC + 2 * STEP_V;
        end else if (retire) begin
            cur.pc   <= exec_npc;
            cur.npc  <= exec_nnpc;
            cur.nnpc <= exec_nnpc + STEP_V;
        end
    end
endmodule

// File: rtl/dsnpc_unit.sv
module dsnpc_unit
    import dsnpc_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0040_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire,
    input  logic [2:0]       xfer_class,
    input  logic             link_en,
    input  logic             cond_true,
    input  logic             cond_forced,
    input  logic [OFF_W-1:0] offset,
    input  logic [IDX_W-1:0] jump_index,
    input  logic [PC_W-1:0]  reg_value,
    output logic [PC_W-1:0]  pc,
    output logic [PC_W-1:0]  npc,
    output logic [PC_W-1:0]  nnpc,
    output logic             link_we,
    output logic [PC_W-1:0]  link_data,
    output logic             annul
);
    dec_t            dec;
    tgt_t            tgt;
    pc_trip_t        cur;
    logic [PC_W-1:0] exec_npc;
    logic [PC_W-1:0] exec_nnpc;

    dsnpc_decode u_dec (
        .cls_raw (xfer_class),
        .link_en (link_en),
        .dec     (dec)
    );

    dsnpc_target u_tgt (
        .npc        (cur.npc),
        .offset     (offset),
        .jump_index (jump_index),
        .reg_value  (reg_value),
        .tgt        (tgt)
    );

    dsnpc_resolve u_res (
        .retire      (retire),
        .dec         (dec),
        .cond_true   (cond_true),
        .cond_forced (cond_forced),
        .cur         (cur),
        .tgt         (tgt),
        .exec_npc    (exec_npc),
        .exec_nnpc   (exec_nnpc),
        .annul       (annul),
        .link_we     (link_we)
    );

    dsnpc_state #(.RESET_VEC(RESET_VEC)) u_st (
        .clk       (clk),
        .rst       (rst),
        .retire    (retire),
        .exec_npc  (exec_npc),
        .exec_nnpc (exec_nnpc),
        .cur       (cur)
    );

    assign pc        = cur.pc;
    assign npc       = cur.npc;
    assign nnpc      = cur.nnpc;
    assign link_data = cur.nnpc;
endmodule

// File: rtl/dsnpc_unit_chk.sv
module dsnpc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        retire,
    input logic [2:0]  xfer_class,
    input logic        link_en,
    input logic        cond_true,
    input logic        cond_forced,
    input logic [31:0] pc,
    input logic [31:0] npc,
    input logic [31:0] nnpc,
    input logic        link_we,
    input logic [31:0] link_data,
    input logic        annul
);
    logic plain;
    logic ctrl;
    assign plain = (xfer_class == 3'd0) || (xfer_class > 3'd4);
    assign ctrl  = !plain;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(pc) && $stable(npc) && $stable(nnpc)); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !retire |-> !annul && !link_we); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        retire && plain |=> pc == $past(npc) && npc == $past(nnpc)
                            && nnpc == $past(nnpc) + 32'd4); // R3

    AST_PAIR_GAP: assert property (@(posedge clk) disable iff (rst)
        retire |=> nnpc == npc + 32'd4); // R4

    AST_ANNUL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        annul |-> retire && xfer_class == 3'd2 && !cond_true && !cond_forced); // R6

    AST_ANNUL_SKIP: assert property (@(posedge clk) disable iff (rst)
        annul |=> pc == $past(nnpc)); // R6

    AST_FORCED_TAKEN: assert property (@(posedge clk) disable iff (rst)
        retire && xfer_class == 3'd2 && cond_forced |-> !annul); // R7

    AST_JREG_MODE: assert property (@(posedge clk) disable iff (rst)
        retire && xfer_class == 3'd4 |=> npc[1] == 1'b0 && npc[0] == $past(npc[0])); // R9

    AST_LINK_GATE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> retire && link_en && ctrl); // R10

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_data == nnpc); // R10
endmodule

bind dsnpc_unit dsnpc_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .retire      (retire),
    .xfer_class  (xfer_class),
    .link_en     (link_en),
    .cond_true   (cond_true),
    .cond_forced (cond_forced),
    .pc          (pc),
    .npc         (npc),
    .nnpc        (nnpc),
    .link_we     (link_we),
    .link_data   (link_data),
    .annul       (annul)
);

// File: tb/dsnpc_unit_tb_top.sv
module dsnpc_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    typedef struct packed {
        logic [2:0]  cls;
        logic        lnk;
        logic        cnd;
        logic        frc;
        logic [15:0] off;
        logic [25:0] idx;
        logic [31:0] rv;
        logic        e_ann;
        logic        e_lwe;
        logic [31:0] e_ld;
        logic [31:0] e_pc;
        logic [31:0] e_npc;
        logic [31:0] e_nnpc;
        logic [7:0]  req;
    } vec_t;

    // Start state after reset with RESET_VEC 0x1000_0000: 10000000/10000004/10000008
    localparam vec_t VECS [NVEC] = '{
        // R3 plain step
        '{3'd0,1'b0,1'b0,1'b0,16'h0000,26'h0,32'h0,1'b0,1'b0,32'h0,32'h10000004,32'h10000008,32'h1000000C,8'd3},
        // R4 taken branch, disp 0x40 from npc
        '{3'd1,1'b0,1'b1,1'b0,16'h0010,26'h0,32'h0,1'b0,1'b0,32'h0,32'h10000008,32'h10000048,32'h1000004C,8'd4},
        // R3 delay slot
        '{3'd0,1'b0,1'b0,1'b0,16'h0000,26'h0,32'h0,1'b0,1'b0,32'h0,32'h10000048,32'h1000004C,32'h10000050,8'd3},
        // R5 not-taken ordinary branch
        '{3'd1,1'b0,1'b0,1'b0,16'h0100,26'h0,32'h0,1'b0,1'b0,32'h0,32'h1000004C,32'h10000050,32'h10000054,8'd5},
        // R6 likely not taken: annul, skip
        '{3'd2,1'b0,1'b0,1'b0,16'h0005,26'h0,32'h0,1'b1,1'b0,32'h0,32'h10000054,32'h10000058,32'h1000005C,8'd6},
        // R6 likely taken, backward disp -16
        '{3'd2,1'b0,1'b1,1'b0,16'hFFFC,26'h0,32'h0,1'b0,1'b0,32'h0,32'h10000058,32'h10000048,32'h1000004C,8'd6},
        // R3
        '{3'd0,1'b0,1'b0,1'b0,16'h0000,26'h0,32'h0,1'b0,1'b0,32'h0,32'h10000048,32'h1000004C,32'h10000050,8'd3},
        // R7 R11 forced branch with link, offset 0x8000 -> -0x20000
        '{3'd1,1'b1,1'b0,1'b1,16'h8000,26'h0,32'h0,1'b0,1'b1,32'h10000050,32'h1000004C,32'h0FFE004C,32'h0FFE0050,8'd7},
        // R3
        '{3'd0,1'b0,1'b0,1'b0,16'h0000,26'h0,32'h0,1'b0,1'b0,32'h0,32'h0FFE004C,32'h0FFE0050,32'h0FFE0054,8'd3},
        // R8 direct jump with link
        '{3'd3,1'b1,1'b0,1'b0,16'h0000,26'h0000100,32'h0,1'b0,1'b1,32'h0FFE0054,32'h0FFE0050,32'h00000400,32'h00000404,8'd8},
        // R3
        '{3'd0,1'b0,1'b0,1'b0,16'h0000,26'h0,32'h0,1'b0,1'b0,32'h0,32'h00000400,32'h00000404,32'h00000408,8'd3},
        // R9 register jump, low bits cleared
        '{3'd4,1'b0,1'b0,1'b0,16'h0000,26'h0,32'h20000123,1'b0,1'b0,32'h0,32'h00000404,32'h20000120,32'h20000124,8'd9},
        // R3
        '{3'd0,1'b0,1'b0,1'b0,16'h0000,26'h0,32'h0,1'b0,1'b0,32'h0,32'h20000120,32'h20000124,32'h20000128,8'd3},
        // R10 likely not taken with link: link still written, annul
        '{3'd2,1'b1,1'b0,1'b0,16'h0040,26'h0,32'h0,1'b1,1'b1,32'h20000128,32'h20000128,32'h2000012C,32'h20000130,8'd10},
        // R10 plain instruction with link flag: no write
        '{3'd0,1'b1,1'b1,1'b0,16'h0000,26'h0,32'h0,1'b0,1'b0,32'h0,32'h2000012C,32'h20000130,32'h20000134,8'd10},
        // R3 unused class code 6
        '{3'd6,1'b1,1'b1,1'b1,16'h0010,26'h3FF,32'hFFFF,1'b0,1'b0,32'h0,32'h20000130,32'h20000134,32'h20000138,8'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire = 1'b0;
    logic [2:0]  xfer_class = 3'd0;
    logic        link_en = 1'b0;
    logic        cond_true = 1'b0;
    logic        cond_forced = 1'b0;
    logic [15:0] offset = 16'h0;
    logic [25:0] jump_index = 26'h0;
    logic [31:0] reg_value = 32'h0;
    logic [31:0] pc, npc, nnpc, link_data;
    logic        link_we, annul;
    logic [31:0] pc_o, npc_o, nnpc_o, link_data_o;
    logic        link_we_o, annul_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsnpc_unit #(.RESET_VEC(32'h1000_0000)) dut_i (
        .clk(clk), .rst(rst), .retire(retire), .xfer_class(xfer_class),
        .link_en(link_en), .cond_true(cond_true), .cond_forced(cond_forced),
        .offset(offset), .jump_index(jump_index), .reg_value(reg_value),
        .pc(pc), .npc(npc), .nnpc(nnpc), .link_we(link_we),
        .link_data(link_data), .annul(annul)
    );

    dsnpc_unit #(.RESET_VEC(32'h0000_1001)) dut_odd (
        .clk(clk), .rst(rst), .retire(retire), .xfer_class(xfer_class),
        .link_en(link_en), .cond_true(cond_true), .cond_forced(cond_forced),
        .offset(offset), .jump_index(jump_index), .reg_value(reg_value),
        .pc(pc_o), .npc(npc_o), .nnpc(nnpc_o), .link_we(link_we_o),
        .link_data(link_data_o), .annul(annul_o)
    );

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic ret);
        retire      = ret;
        xfer_class  = v.cls;
        link_en     = v.lnk;
        cond_true   = v.cnd;
        cond_forced = v.frc;
        offset      = v.off;
        jump_index  = v.idx;
        reg_value   = v.rv;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check32("R1", "pc", pc, 32'h10000000);
        check32("R1", "npc", npc, 32'h10000004);
        check32("R1", "nnpc", nnpc, 32'h10000008);
        check32("R1", "odd pc", pc_o, 32'h00001001);

        // R2 hold: a taken linking branch presented without retire
        drive('{3'd1,1'b1,1'b1,1'b0,16'h0010,26'h0,32'h0,1'b0,1'b0,32'h0,32'h0,32'h0,32'h0,8'd2}, 1'b0);
        #1;
        check32("R2", "annul idle", {31'b0, annul}, 32'h0);
        check32("R2", "link_we idle", {31'b0, link_we}, 32'h0);
        @(posedge clk); #1;
        check32("R2", "pc held", pc, 32'h10000000);
        check32("R2", "npc held", npc, 32'h10000004);
        check32("R2", "nnpc held", nnpc, 32'h10000008);

        for (int i = 0; i < NVEC; i++) begin
            string rq;
            @(negedge clk);
            drive(VECS[i], 1'b1);
            rq = $sformatf("R%0d vec%0d", VECS[i].req, i);
            #1;
            check32(rq, "annul", {31'b0, annul}, {31'b0, VECS[i].e_ann});
            check32(rq, "link_we", {31'b0, link_we}, {31'b0, VECS[i].e_lwe});
            if (VECS[i].e_lwe) check32(rq, "link_data", link_data, VECS[i].e_ld);
            if (i == 0) begin
                @(posedge clk); #1;
                retire = 1'b0;
                // R9: odd-vector instance sees a plain step first
                check32("R9", "odd npc", npc_o, 32'h00001009);
            end else begin
                @(posedge clk); #1;
            end
            check32(rq, "pc", pc, VECS[i].e_pc);
            check32(rq, "npc", npc, VECS[i].e_npc);
            check32(rq, "nnpc", nnpc, VECS[i].e_nnpc);
        end

        // R9 odd mode bit: reset the odd instance path and jump through a register
        @(negedge clk);
        retire = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check32("R1", "odd npc reset", npc_o, 32'h00001005);
        drive('{3'd4,1'b0,1'b0,1'b0,16'h0,26'h0,32'h00002003,1'b0,1'b0,32'h0,32'h0,32'h0,32'h0,8'd9}, 1'b1);
        @(posedge clk); #1;
        retire = 1'b0;
        check32("R9", "odd pc", pc_o, 32'h00001005);
        check32("R9", "odd npc keeps bit0", npc_o, 32'h00002001);
        check32("R9", "odd nnpc", nnpc_o, 32'h00002005);
        check32("R9", "even npc clears bit0", npc, 32'h00002000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule